// File: doc/BRIEF.md
# Cascadeable Interval Timer Set

This block holds three down-counting interval timers behind a small register port. The first timer is 32 bits wide and the other two are 16 bits wide. Each timer counts down from a value that software loads. When it reaches zero it flags an interrupt. It then either stops there (one-shot) or reloads itself and keeps going (auto-restart).

All timers share one prescaled tick pulse. A timer can instead be chained to the timer before it. It then steps only on that timer's terminal-count pulse, which makes a wider counter or a longer period out of the chain 1 → 2 → 3.

Software reaches the block through a single write/read strobe pair and a 4-bit word address.

Each timer has two words:
- a load word at byte-free address `4*n`, which reads back the live count;
- a control word at `4*n+1`.

Address 12 holds the shared pending-interrupt word. Reads return data one cycle after the read strobe.

Top module: `itm_timer_set`

## Requirements
- R1: After reset every count, control word and pending bit is zero, `irq_o` is 0 and `rdata_o` is 0.
- R2: A write to a load word (timer n at address 4*n) primes the live count when the timer is idle, meaning its run bit is clear or its count is zero. When the timer is counting, the write only replaces the reload value and leaves the live count alone.
- R3: A running timer that is not chained drops its count by one on each cycle where `tick_i` is high, and holds its count on cycles without a tick.
- R4: In one-shot mode (control bit 1 clear), a timer that steps from 1 to 0 sets its pending bit and then holds at 0 through later ticks.
- R5: In auto-restart mode (control bit 1 set), the step from 1 loads the reload value instead of 0, and the pending bit is set on every such wrap.
- R6: Timer 2 with its chain bit set (control bit 2) steps only on timer 1's terminal-count cycle and ignores `tick_i`.
- R7: Timer 3 with its chain bit set steps only on timer 2's terminal-count cycle, so a tick can ripple through all three timers in one cycle.
- R8: A pending bit (bit n of the word at address 12) stays set until a write to address 12 with a 1 in bit n. Writing 0 to that bit leaves it set.
- R9: `irq_o[n]` is high exactly when pending bit n and the interrupt-enable bit of timer n (control bit 3) are both set. A pending bit still sets while the enable bit is clear.
- R10: Timers 2 and 3 keep only the low 16 bits of a load write, and their count reads back zero-extended to 32 bits.
- R11: The chain bit of timer 1 has no effect, so timer 1 always steps on `tick_i`.
- R12: The control word's run bit is bit 0. A timer with run clear neither steps nor raises a terminal count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Common prescaled step pulse |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after `rd_en_i` |
| irq_o | output | 3 | Per-timer interrupt, pending AND enable |

## Verification
The assertions check the following rules on every cycle:
- a count never moves without a step event or a load write;
- a one-shot timer at zero stays there;
- every terminal count leaves its pending bit set;
- a pending bit only falls after a write-1 to the pending word;
- `irq_o` never rises without the matching pending bit.

The bench scenarios must show the following:
- the actual count values;
- the reload value after an auto-restart wrap;
- the ripple of counts through the cascade;
- the effect of a load write while a timer is counting;
- 16-bit truncation;
- that timer 1 ignores its chain bit.

// File: rtl/itm_pkg.sv
package itm_pkg;
  localparam int NUM_TMR = 3;
  localparam int REG_AW  = 4;
  localparam logic [REG_AW-1:0] STAT_ADDR = 4'hC;

  typedef struct packed {
    logic irq_en;   // bit 3
    logic chain;    // bit 2
    logic auto_rl;  // bit 1
    logic run;      // bit 0
  } tmr_ctrl_t;

  function automatic logic [REG_AW-1:0] load_addr(input int idx);
    return REG_AW'(idx * 4);
  endfunction

  function automatic logic [REG_AW-1:0] ctrl_addr(input int idx);
    return REG_AW'(idx * 4 + 1);
  endfunction
endpackage

// File: rtl/itm_counter.sv
module itm_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         auto_rl,
  input  logic         step,
  input  logic         ld_stb,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] count,
  output logic         tc
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] reload_q;
  logic [W-1:0] count_q;
  logic         idle;
  logic         adv;

  assign idle  = !run || (count_q == '0);
  assign adv   = run && step && (count_q != '0);
  assign tc    = adv && (count_q == ONE);
  assign count = count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      count_q  <= '0;
    end else begin
      if (ld_stb)
        reload_q <= ld_val;
      if (ld_stb && idle)
        count_q <= ld_val;
      else if (adv)
        count_q <= (count_q == ONE && auto_rl) ? reload_q : count_q - ONE;
    end
  end
endmodule

// File: rtl/itm_regs.sv
module itm_regs
  import itm_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [REG_AW-1:0]             addr,
  input  logic [3:0]                    ctl_wd,
  input  logic [NUM_TMR-1:0]            tc,
  input  logic [NUM_TMR-1:0][DW-1:0]    cnt_ext,
  output logic [NUM_TMR-1:0]            run_v,
  output logic [NUM_TMR-1:0]            auto_v,
  output logic [NUM_TMR-1:0]            chain_v,
  output logic [NUM_TMR-1:0]            ld_stb,
  output logic [NUM_TMR-1:0]            pend,
  output logic [NUM_TMR-1:0]            irq,
  output logic [DW-1:0]                 rdata
);
  tmr_ctrl_t          ctrl_q [NUM_TMR];
  tmr_ctrl_t          ctrl_n [NUM_TMR];
  logic [NUM_TMR-1:0] en_n;
  logic [NUM_TMR-1:0] clr;
  logic [NUM_TMR-1:0] pend_q;
  logic [NUM_TMR-1:0] pend_n;
  logic [NUM_TMR-1:0] irq_q;
  logic [DW-1:0]      rd_mux;
  logic [DW-1:0]      rdata_q;

  always_comb begin
    for (int i = 0; i < NUM_TMR; i++) begin
      ctrl_n[i] = ctrl_q[i];
      if (wr_en && addr == ctrl_addr(i))
        ctrl_n[i] = tmr_ctrl_t'(ctl_wd);
      en_n[i]    = ctrl_n[i].irq_en;
      ld_stb[i]  = wr_en && (addr == load_addr(i));
      run_v[i]   = ctrl_q[i].run;
      auto_v[i]  = ctrl_q[i].auto_rl;
      chain_v[i] = ctrl_q[i].chain;
    end
  end

  assign clr    = (wr_en && addr == STAT_ADDR) ? ctl_wd[NUM_TMR-1:0] : '0;
  assign pend_n = (pend_q & ~clr) | tc;

  always_comb begin
    rd_mux = '0;
    if (addr == STAT_ADDR)
      rd_mux = DW'(pend_q);
    for (int i = 0; i < NUM_TMR; i++) begin
      if (addr == load_addr(i)) rd_mux = cnt_ext[i];
      if (addr == ctrl_addr(i)) rd_mux = DW'(ctrl_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_TMR; i++) ctrl_q[i] <= '0;
      pend_q  <= '0;
      irq_q   <= '0;
      rdata_q <= '0;
    end else begin
      for (int i = 0; i < NUM_TMR; i++) ctrl_q[i] <= ctrl_n[i];
      pend_q <= pend_n;
      irq_q  <= pend_n & en_n;
      if (rd_en) rdata_q <= rd_mux;
    end
  end

  assign pend  = pend_q;
  assign irq   = irq_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/itm_timer_set.sv
module itm_timer_set
  import itm_pkg::*;
#(
  parameter int DW   = 32,
  parameter int T1_W = 32,
  parameter int T2_W = 16,
  parameter int T3_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_i,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [REG_AW-1:0]   addr_i,
  input  logic [DW-1:0]       wdata_i,
  output logic [DW-1:0]       rdata_o,
  output logic [NUM_TMR-1:0]  irq_o
);
  logic [NUM_TMR-1:0]         run_v;
  logic [NUM_TMR-1:0]         auto_v;
  logic [NUM_TMR-1:0]         chain_v;
  logic [NUM_TMR-1:0]         ld_stb;
  logic [NUM_TMR-1:0]         pend;
  logic [NUM_TMR-1:0]         tc;
  logic [NUM_TMR-1:0]         step;
  logic [NUM_TMR-1:0][DW-1:0] cnt_ext;

  itm_regs #(.DW(DW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en_i),
    .rd_en   (rd_en_i),
    .addr    (addr_i),
    .ctl_wd  (wdata_i[3:0]),
    .tc      (tc),
    .cnt_ext (cnt_ext),
    .run_v   (run_v),
    .auto_v  (auto_v),
    .chain_v (chain_v),
    .ld_stb  (ld_stb),
    .pend    (pend),
    .irq     (irq_o),
    .rdata   (rdata_o)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    localparam int TW = (g == 0) ? T1_W : ((g == 1) ? T2_W : T3_W);
    logic [TW-1:0] cnt_w;

    if (g == 0) begin : g_head
      assign step[g] = tick_i;
    end else begin : g_link
      assign step[g] = chain_v[g] ? tc[g-1] : tick_i;
    end

    itm_counter #(.W(TW)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .run     (run_v[g]),
      .auto_rl (auto_v[g]),
      .step    (step[g]),
      .ld_stb  (ld_stb[g]),
      .ld_val  (wdata_i[TW-1:0]),
      .count   (cnt_w),
      .tc      (tc[g])
    );

    assign cnt_ext[g] = DW'(cnt_w);
  end
endmodule

// File: rtl/itm_checker.sv
module itm_checker
  import itm_pkg::*;
#(
  parameter int DW = 32
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        tick_i,
  input logic                        wr_en_i,
  input logic [REG_AW-1:0]           addr_i,
  input logic [DW-1:0]               wdata_i,
  input logic [NUM_TMR-1:0]          irq_o,
  input logic [NUM_TMR-1:0]          pend,
  input logic [NUM_TMR-1:0][DW-1:0]  cnt_ext,
  input logic [NUM_TMR-1:0]          run_v,
  input logic [NUM_TMR-1:0]          auto_v,
  input logic [NUM_TMR-1:0]          chain_v,
  input logic [NUM_TMR-1:0]          ld_stb,
  input logic [NUM_TMR-1:0]          tc
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (irq_o == '0 && pend == '0));

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
    logic evt;
    if (i == 0) begin : g_e0
      assign evt = tick_i;
    end else begin : g_en
      assign evt = chain_v[i] ? tc[i-1] : tick_i;
    end

    // R3, R6, R7, R12: count moves only on its own step event or a load write
    assert_hold_without_step_R3: assert property (@(posedge clk) disable iff (rst)
      (!ld_stb[i] && !(run_v[i] && evt)) |=> $stable(cnt_ext[i]));

    assert_oneshot_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (!auto_v[i] && cnt_ext[i] == '0 && !ld_stb[i]) |=> (cnt_ext[i] == '0));

    assert_tc_sets_pending_R5: assert property (@(posedge clk) disable iff (rst)
      tc[i] |=> pend[i]);

    assert_clear_needs_write_R8: assert property (@(posedge clk) disable iff (rst)
      $fell(pend[i]) |-> $past(wr_en_i && addr_i == STAT_ADDR && wdata_i[i]));

    assert_irq_needs_pending_R9: assert property (@(posedge clk) disable iff (rst)
      irq_o[i] |-> pend[i]);
  end
endmodule

bind itm_timer_set itm_checker #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick_i  (tick_i),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .irq_o   (irq_o),
  .pend    (pend),
  .cnt_ext (cnt_ext),
  .run_v   (run_v),
  .auto_v  (auto_v),
  .chain_v (chain_v),
  .ld_stb  (ld_stb),
  .tc      (tc)
);

// File: tb/itm_timer_set_test.sv
module itm_timer_set_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        tick = 0;
  logic        wr_en = 0;
  logic        rd_en = 0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  irq;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  itm_timer_set uut (
    .clk(clk), .rst(rst), .tick_i(tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  localparam logic [3:0] L0 = 4'd0, C0 = 4'd1, L1 = 4'd4, C1 = 4'd5;
  localparam logic [3:0] L2 = 4'd8, C2 = 4'd9, ST = 4'd12;

  typedef struct packed {
    logic [31:0] ld;
    logic [7:0]  n;
    logic [31:0] exp;
    logic        pd;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{32'd10,         8'd3, 32'd7,          1'b0},
    '{32'd5,          8'd5, 32'd0,          1'b1},
    '{32'd4,          8'd9, 32'd0,          1'b1},
    '{32'd0,          8'd3, 32'd0,          1'b0},
    '{32'hFFFF_FFFF,  8'd2, 32'hFFFF_FFFD,  1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    do_reset();
    // R1 reset state
    chk("R1 irq", {29'd0, irq}, 32'd0);
    chk("R1 rdata", rdata, 32'd0);
    rd(L0, v); chk("R1 count0", v, 0);
    rd(C2, v); chk("R1 ctrl2", v, 0);
    rd(ST, v); chk("R1 pending", v, 0);

    // Vector table: timer 1 one-shot, R3/R4/R12
    for (int i = 0; i < 5; i++) begin
      wr(C0, 0);
      wr(ST, 7);
      wr(L0, VEC[i].ld);
      ticks(2);
      rd(L0, v); chk("R12 stopped no step", v, VEC[i].ld);
      wr(C0, 1);
      ticks(int'(VEC[i].n));
      rd(L0, v); chk("R3 vector count", v, VEC[i].exp);
      rd(ST, v); chk("R4 vector pending", v, {31'd0, VEC[i].pd});
    end

    // R2 / R4 load while counting, one-shot hold
    do_reset();
    wr(L0, 10); wr(C0, 1); ticks(2);
    rd(L0, v); chk("R2 count before", v, 8);
    wr(L0, 20);
    rd(L0, v); chk("R2 write while counting", v, 8);
    repeat (4) @(negedge clk);
    rd(L0, v); chk("R3 no tick holds", v, 8);
    ticks(8);
    rd(L0, v); chk("R4 reached zero", v, 0);
    ticks(3);
    rd(L0, v); chk("R4 holds at zero", v, 0);
    rd(ST, v); chk("R4 pending", v, 1);
    wr(L0, 6);
    rd(L0, v); chk("R2 prime at zero", v, 6);

    // R5 auto-restart, R8 sticky pending
    do_reset();
    wr(L0, 3); wr(C0, 3); ticks(3);
    rd(L0, v); chk("R5 reload", v, 3);
    rd(ST, v); chk("R5 pending wrap1", v, 1);
    wr(ST, 0);
    rd(ST, v); chk("R8 write zero keeps", v, 1);
    wr(ST, 1);
    rd(ST, v); chk("R8 write one clears", v, 0);
    ticks(4);
    rd(L0, v); chk("R5 after second wrap", v, 2);
    rd(ST, v); chk("R5 pending wrap2", v, 1);

    // R9 enable gating
    do_reset();
    wr(L0, 2); wr(C0, 3); ticks(2);
    chk("R9 irq masked", {29'd0, irq}, 0);
    rd(ST, v); chk("R9 pending while masked", v, 1);
    wr(C0, 32'hB);
    chk("R9 irq enabled", {29'd0, irq}, 1);
    wr(ST, 1);
    chk("R9 irq cleared", {29'd0, irq}, 0);

    // R6 cascade 1 -> 2
    do_reset();
    wr(L0, 2); wr(L1, 5); wr(C0, 3); wr(C1, 5);
    ticks(1);
    rd(L1, v); chk("R6 no step on tick", v, 5);
    ticks(5);
    rd(L1, v); chk("R6 steps on tc", v, 2);
    rd(L0, v); chk("R6 head count", v, 2);

    // R7 cascade 1 -> 2 -> 3
    do_reset();
    wr(L0, 1); wr(L1, 2); wr(L2, 10);
    wr(C0, 3); wr(C1, 7); wr(C2, 5);
    ticks(6);
    rd(L2, v); chk("R7 third timer", v, 7);
    rd(L1, v); chk("R7 middle timer", v, 2);
    rd(ST, v); chk("R7 pending", v, 3);

    // R10 truncation, R11 chain bit on timer 1 ignored
    do_reset();
    wr(L1, 32'h1234_ABCD);
    rd(L1, v); chk("R10 truncated", v, 32'h0000_ABCD);
    wr(L0, 4); wr(C0, 5); ticks(1);
    rd(L0, v); chk("R11 timer1 ignores chain", v, 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule